// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Unit

This unit watches the running clock's minutes, hours and day-of-week and raises an alarm when they agree with three programmable alarm registers. Bit 7 of each alarm register is a mask. The masks are cascaded, so the one alarm can repeat every minute, every hour, every day or once a week. A firing sets a sticky flag. The flag drives an interrupt, and software can hold the interrupt off with a mask bit from the command register. The interrupt is either a level or a pulse that lasts a set number of 100 Hz ticks.

The clock core supplies the candidate time together with a rollover strobe, which it issues in the cycle where hundredths are at 99. In that cycle the inputs carry the time that takes effect at the rollover, and `sec_wrap` marks that the seconds are wrapping from 59 to 00. Whenever software reads or writes any of the three alarm registers, the flag and the interrupt clear. A routing bit decides which interrupt pin carries this alarm. The other pin carries an external watchdog interrupt.

Top module: `tod_alarm_unit`

## Requirements
- R1: After a synchronous reset, `tod_flag` is 0 and all three alarm registers read 0. While `wdog_irq` is 0, `int_a` and `int_b` are both 0.
- R2: Select 0 is the minutes alarm and select 1 is the hours alarm. Both read back all 8 bits as written. Select 2 is the day alarm, which stores bits 7 and 2:0 and always reads bits 6:3 as 0. Select 3 reads 0, and a write to it has no effect.
- R3: When all three masks are clear (bit 7 of minutes, hours and day alarm = 0), the alarm fires only if minutes (bits 6:0), hours (bits 6:0) and day (bits 2:0) all equal the candidate time.
- R4: When only the day mask is set, the alarm fires when minutes and hours match, whatever the day.
- R5: When the day and hours masks are set and the minutes mask is clear, the alarm fires when minutes match, whatever the hours and day.
- R6: When all three masks are set, the alarm fires at every minute rollover, whatever the register contents.
- R7: Any other mask combination never fires.
- R8: A firing needs `roll_stb` and `sec_wrap` high in the same cycle. Without both, a match has no effect.
- R9: `tod_flag` goes to 1 one clock after the firing strobe. In level mode (`cmd_pulse` = 0) it stays at 1 until an alarm register access, which clears it one clock later. If an access and a firing land in the same cycle, the access wins.
- R10: `cmd_tod_mask` = 1 keeps this alarm's interrupt pin inactive. `tod_flag` still sets.
- R11: In pulse mode (`cmd_pulse` = 1), the flag and interrupt stay at 1 until the (PULSE_TICKS+1)-th `tick_100hz` after the firing, and drop one clock after that tick.
- R12: `cmd_route_a` = 1 puts this alarm on `int_a` and `wdog_irq` on `int_b`. A value of 0 swaps the two pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_100hz | input | 1 | One-cycle strobe every 10 ms |
| roll_stb | input | 1 | Evaluation strobe, once per hundredths-99 period |
| sec_wrap | input | 1 | Seconds wrap 59 to 00 at this rollover |
| cur_min | input | 7 | Candidate minutes, BCD |
| cur_hour | input | 7 | Candidate hours, BCD plus format bits |
| cur_day | input | 3 | Candidate day of week |
| reg_sel | input | 2 | Alarm register select (0 min, 1 hour, 2 day) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cmd_tod_mask | input | 1 | Suppress alarm interrupt when 1 |
| cmd_pulse | input | 1 | Pulse mode when 1, level mode when 0 |
| cmd_route_a | input | 1 | Alarm on int_a when 1, on int_b when 0 |
| wdog_irq | input | 1 | Watchdog interrupt to be routed |
| int_a | output | 1 | Interrupt pin A, active high |
| int_b | output | 1 | Interrupt pin B, active high |
| tod_flag | output | 1 | Alarm flag readback |

## Verification
A firing strobe or an access strobe passes through one register, so the flag, and with it the interrupt pins, change one clock after the edge that samples the strobe. The bench drives each strobe on a falling edge and removes it on the next falling edge, then samples the result right there, one rising edge later. The read data, routing and interrupt masking are combinational from their inputs and the stored state, so they are sampled in the same half cycle as the stimulus. In the pulse test, the flag is checked after each tick, and the bench expects it to release only after the second tick at the default width.

// File: rtl/tod_alarm_pkg.sv
`timescale 1ns/1ps
package tod_alarm_pkg;

    localparam int BYTE_W = 8;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 7;
    localparam int DAY_W  = 3;

    typedef enum logic [1:0] {
        SEL_MIN  = 2'd0,
        SEL_HOUR = 2'd1,
        SEL_DAY  = 2'd2,
        SEL_NONE = 2'd3
    } alm_sel_e;

    typedef enum logic [2:0] {
        MODE_WEEKLY,
        MODE_DAILY,
        MODE_HOURLY,
        MODE_MINUTE,
        MODE_OFF
    } alm_mode_e;

    typedef struct packed {
        logic [MIN_W-1:0]  min;
        logic [HOUR_W-1:0] hour;
        logic [DAY_W-1:0]  day;
    } tod_t;

    typedef struct packed {
        logic m_min;
        logic m_hour;
        logic m_day;
        tod_t val;
    } alm_cfg_t;

    // Cascaded masks: each coarser field masked before any finer one
    function automatic alm_mode_e decode_mode(input logic m_min,
                                              input logic m_hour,
                                              input logic m_day);
        case ({m_day, m_hour, m_min})
            3'b000:  return MODE_WEEKLY;
            3'b100:  return MODE_DAILY;
            3'b110:  return MODE_HOURLY;
            3'b111:  return MODE_MINUTE;
            default: return MODE_OFF;
        endcase
    endfunction

endpackage

// File: rtl/alarm_regs.sv
`timescale 1ns/1ps
module alarm_regs
    import tod_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output alm_cfg_t          cfg
);

    alm_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_MIN: begin
                    cfg_q.m_min   <= wdata[BYTE_W-1];
                    cfg_q.val.min <= wdata[MIN_W-1:0];
                end
                SEL_HOUR: begin
                    cfg_q.m_hour   <= wdata[BYTE_W-1];
                    cfg_q.val.hour <= wdata[HOUR_W-1:0];
                end
                SEL_DAY: begin
                    cfg_q.m_day   <= wdata[BYTE_W-1];
                    cfg_q.val.day <= wdata[DAY_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_MIN:  rdata = {cfg_q.m_min, cfg_q.val.min};
            SEL_HOUR: rdata = {cfg_q.m_hour, cfg_q.val.hour};
            SEL_DAY:  rdata = {cfg_q.m_day, {(BYTE_W-1-DAY_W){1'b0}}, cfg_q.val.day};
            default:  rdata = '0;
        endcase
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/alarm_match.sv
`timescale 1ns/1ps
module alarm_match
    import tod_alarm_pkg::*;
(
    input  alm_cfg_t cfg,
    input  tod_t     now,
    input  logic     roll_stb,
    input  logic     sec_wrap,
    output logic     fire
);

    alm_mode_e mode;
    logic      eq_min, eq_hour, eq_day, hit;

    assign mode    = decode_mode(cfg.m_min, cfg.m_hour, cfg.m_day);
    assign eq_min  = (cfg.val.min  == now.min);
    assign eq_hour = (cfg.val.hour == now.hour);
    assign eq_day  = (cfg.val.day  == now.day);

    always_comb begin
        case (mode)
            MODE_WEEKLY: hit = eq_min & eq_hour & eq_day;
            MODE_DAILY:  hit = eq_min & eq_hour;
            MODE_HOURLY: hit = eq_min;
            MODE_MINUTE: hit = 1'b1;
            default:     hit = 1'b0;
        endcase
    end

    assign fire = roll_stb & sec_wrap & hit;

endmodule

// File: rtl/alarm_flag_ctl.sv
`timescale 1ns/1ps
module alarm_flag_ctl #(
    parameter int PULSE_TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic acc,
    input  logic tick,
    input  logic pulse_mode,
    output logic flag
);

    localparam int CNT_W = $clog2(PULSE_TICKS + 2);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_TICKS + 1);

    logic             flag_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            cnt_q  <= '0;
        end else if (acc) begin
            flag_q <= 1'b0;
            cnt_q  <= '0;
        end else if (fire) begin
            flag_q <= 1'b1;
            cnt_q  <= LOAD;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1) && pulse_mode)
                flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/tod_alarm_unit.sv
`timescale 1ns/1ps
module tod_alarm_unit
    import tod_alarm_pkg::*;
#(
    parameter int PULSE_TICKS = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_100hz,
    input  logic        roll_stb,
    input  logic        sec_wrap,
    input  logic [6:0]  cur_min,
    input  logic [6:0]  cur_hour,
    input  logic [2:0]  cur_day,
    input  logic [1:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        cmd_tod_mask,
    input  logic        cmd_pulse,
    input  logic        cmd_route_a,
    input  logic        wdog_irq,
    output logic        int_a,
    output logic        int_b,
    output logic        tod_flag
);

    alm_cfg_t cfg;
    tod_t     now;
    logic     fire, acc, flag, tod_int;

    assign now = '{min: cur_min, hour: cur_hour, day: cur_day};
    assign acc = (reg_wr | reg_rd) & (reg_sel != SEL_NONE);

    alarm_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    alarm_match u_match (
        .cfg      (cfg),
        .now      (now),
        .roll_stb (roll_stb),
        .sec_wrap (sec_wrap),
        .fire     (fire)
    );

    alarm_flag_ctl #(.PULSE_TICKS(PULSE_TICKS)) u_flag (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .acc        (acc),
        .tick       (tick_100hz),
        .pulse_mode (cmd_pulse),
        .flag       (flag)
    );

    assign tod_int  = flag & ~cmd_tod_mask;
    assign int_a    = cmd_route_a ? tod_int  : wdog_irq;
    assign int_b    = cmd_route_a ? wdog_irq : tod_int;
    assign tod_flag = flag;

endmodule

// File: rtl/tod_alarm_chk.sv
`timescale 1ns/1ps
module tod_alarm_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_100hz,
    input logic       roll_stb,
    input logic       sec_wrap,
    input logic [1:0] reg_sel,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [7:0] reg_rdata,
    input logic       cmd_tod_mask,
    input logic       cmd_pulse,
    input logic       cmd_route_a,
    input logic       wdog_irq,
    input logic       int_a,
    input logic       int_b,
    input logic       tod_flag
);

    logic acc_seen;
    assign acc_seen = (reg_wr | reg_rd) & (reg_sel != 2'd3);

    // R2
    day_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd2) |-> (reg_rdata[6:3] == 4'd0));

    // R8
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tod_flag) |-> $past(roll_stb && sec_wrap));

    // R9
    access_clears_chk: assert property (@(posedge clk) disable iff (rst)
        acc_seen |=> !tod_flag);

    // R11
    flag_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tod_flag) |-> ($past(acc_seen) || $past(tick_100hz && cmd_pulse)));

    // R10
    masked_pin_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_tod_mask |-> !(cmd_route_a ? int_a : int_b));

    // R12
    wdog_route_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_route_a ? int_b : int_a) == wdog_irq);

endmodule

bind tod_alarm_unit tod_alarm_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .tick_100hz   (tick_100hz),
    .roll_stb     (roll_stb),
    .sec_wrap     (sec_wrap),
    .reg_sel      (reg_sel),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_rdata    (reg_rdata),
    .cmd_tod_mask (cmd_tod_mask),
    .cmd_pulse    (cmd_pulse),
    .cmd_route_a  (cmd_route_a),
    .wdog_irq     (wdog_irq),
    .int_a        (int_a),
    .int_b        (int_b),
    .tod_flag     (tod_flag)
);

// File: tb/tod_alarm_unit_tb_top.sv
`timescale 1ns/1ps
module tod_alarm_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_100hz = 1'b0;
    logic       roll_stb = 1'b0;
    logic       sec_wrap = 1'b0;
    logic [6:0] cur_min = '0;
    logic [6:0] cur_hour = '0;
    logic [2:0] cur_day = '0;
    logic [1:0] reg_sel = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       cmd_tod_mask = 1'b0;
    logic       cmd_pulse = 1'b0;
    logic       cmd_route_a = 1'b1;
    logic       wdog_irq = 1'b0;
    logic       int_a, int_b, tod_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    tod_alarm_unit dut_i (
        .clk(clk), .rst(rst), .tick_100hz(tick_100hz), .roll_stb(roll_stb),
        .sec_wrap(sec_wrap), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_day(cur_day), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_tod_mask(cmd_tod_mask), .cmd_pulse(cmd_pulse),
        .cmd_route_a(cmd_route_a), .wdog_irq(wdog_irq),
        .int_a(int_a), .int_b(int_b), .tod_flag(tod_flag)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic roll(input logic [6:0] m, input logic [6:0] h, input logic [2:0] dy,
                        input logic wrap, input logic stb);
        @(negedge clk);
        cur_min = m; cur_hour = h; cur_day = dy; sec_wrap = wrap; roll_stb = stb;
        @(negedge clk);
        roll_stb = 1'b0; sec_wrap = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_100hz = 1'b1;
        @(negedge clk);
        tick_100hz = 1'b0;
    endtask

    task automatic clear_flag();
        logic [7:0] d;
        rd(2'd0, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 flag", {7'd0, tod_flag}, 8'd0);
        check("R1 int_a", {7'd0, int_a}, 8'd0);
        check("R1 int_b", {7'd0, int_b}, 8'd0);
        rd(2'd0, d); check("R1 min reg", d, 8'h00);
        rd(2'd2, d); check("R1 day reg", d, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(2'd0, 8'hC5); rd(2'd0, d); check("R2 min readback", d, 8'hC5);
        wr(2'd1, 8'h92); rd(2'd1, d); check("R2 hour readback", d, 8'h92);
        wr(2'd2, 8'hFF); rd(2'd2, d); check("R2 day bits 6:3 zero", d, 8'h87);
        wr(2'd3, 8'h55); rd(2'd3, d); check("R2 select 3 reads 0", d, 8'h00);
        rd(2'd0, d); check("R2 select 3 write ignored", d, 8'hC5);
    endtask

    task automatic t_weekly();
        wr(2'd0, 8'h30); wr(2'd1, 8'h12); wr(2'd2, 8'h03);
        roll(7'h30, 7'h12, 3'd4, 1'b1, 1'b1);
        check("R3 day mismatch no fire", {7'd0, tod_flag}, 8'd0);
        roll(7'h30, 7'h12, 3'd3, 1'b0, 1'b1);
        check("R8 no sec_wrap no fire", {7'd0, tod_flag}, 8'd0);
        roll(7'h30, 7'h12, 3'd3, 1'b1, 1'b0);
        check("R8 no roll_stb no fire", {7'd0, tod_flag}, 8'd0);
        roll(7'h30, 7'h12, 3'd3, 1'b1, 1'b1);
        check("R3 full match fires", {7'd0, tod_flag}, 8'd1);
        check("R12 alarm on int_a", {7'd0, int_a}, 8'd1);
        check("R12 int_b idle", {7'd0, int_b}, 8'd0);
        repeat (5) @(negedge clk);
        check("R9 level flag sticky", {7'd0, tod_flag}, 8'd1);
        clear_flag();
        check("R9 read clears flag", {7'd0, tod_flag}, 8'd0);
        check("R9 read clears int", {7'd0, int_a}, 8'd0);
    endtask

    task automatic t_daily();
        wr(2'd0, 8'h15); wr(2'd1, 8'h07); wr(2'd2, 8'h85);
        roll(7'h15, 7'h08, 3'd2, 1'b1, 1'b1);
        check("R4 hour mismatch no fire", {7'd0, tod_flag}, 8'd0);
        roll(7'h15, 7'h07, 3'd2, 1'b1, 1'b1);
        check("R4 daily ignores day", {7'd0, tod_flag}, 8'd1);
        wr(2'd1, 8'h07);
        check("R9 write clears flag", {7'd0, tod_flag}, 8'd0);
    endtask

    task automatic t_hourly();
        wr(2'd0, 8'h42); wr(2'd1, 8'h91); wr(2'd2, 8'h80);
        roll(7'h41, 7'h11, 3'd0, 1'b1, 1'b1);
        check("R5 minute mismatch no fire", {7'd0, tod_flag}, 8'd0);
        roll(7'h42, 7'h05, 3'd6, 1'b1, 1'b1);
        check("R5 hourly ignores hour/day", {7'd0, tod_flag}, 8'd1);
        clear_flag();
    endtask

    task automatic t_minute();
        wr(2'd0, 8'h80); wr(2'd1, 8'h80); wr(2'd2, 8'h80);
        roll(7'h59, 7'h23, 3'd7, 1'b0, 1'b1);
        check("R8 minute mode needs wrap", {7'd0, tod_flag}, 8'd0);
        roll(7'h59, 7'h23, 3'd7, 1'b1, 1'b1);
        check("R6 every minute fires", {7'd0, tod_flag}, 8'd1);
        clear_flag();
    endtask

    task automatic t_illegal();
        wr(2'd0, 8'h90); wr(2'd1, 8'h08); wr(2'd2, 8'h01);
        roll(7'h10, 7'h08, 3'd1, 1'b1, 1'b1);
        check("R7 minutes-only mask no fire", {7'd0, tod_flag}, 8'd0);
        wr(2'd0, 8'h10); wr(2'd1, 8'h88);
        roll(7'h10, 7'h08, 3'd1, 1'b1, 1'b1);
        check("R7 hours-only mask no fire", {7'd0, tod_flag}, 8'd0);
    endtask

    task automatic t_priority();
        wr(2'd0, 8'h80); wr(2'd1, 8'h80); wr(2'd2, 8'h80);
        @(negedge clk);
        roll_stb = 1'b1; sec_wrap = 1'b1; reg_sel = 2'd1; reg_rd = 1'b1;
        @(negedge clk);
        roll_stb = 1'b0; sec_wrap = 1'b0; reg_rd = 1'b0;
        check("R9 access beats firing", {7'd0, tod_flag}, 8'd0);
    endtask

    task automatic t_mask_route();
        cmd_tod_mask = 1'b1;
        roll(7'h00, 7'h00, 3'd0, 1'b1, 1'b1);
        check("R10 flag sets while masked", {7'd0, tod_flag}, 8'd1);
        check("R10 int_a held off", {7'd0, int_a}, 8'd0);
        cmd_tod_mask = 1'b0;
        @(negedge clk);
        cmd_route_a = 1'b0; wdog_irq = 1'b1;
        #1;
        check("R12 swapped alarm on int_b", {7'd0, int_b}, 8'd1);
        check("R12 watchdog on int_a", {7'd0, int_a}, 8'd1);
        clear_flag();
        check("R12 int_b clears", {7'd0, int_b}, 8'd0);
        wdog_irq = 1'b0; cmd_route_a = 1'b1;
    endtask

    task automatic t_pulse();
        cmd_pulse = 1'b1;
        roll(7'h00, 7'h00, 3'd0, 1'b1, 1'b1);
        check("R11 pulse starts", {7'd0, int_a}, 8'd1);
        tick();
        check("R11 held after first tick", {7'd0, tod_flag}, 8'd1);
        tick();
        check("R11 flag released", {7'd0, tod_flag}, 8'd0);
        check("R11 int released", {7'd0, int_a}, 8'd0);
        cmd_pulse = 1'b0;
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_weekly();
        t_daily();
        t_hourly();
        t_minute();
        t_illegal();
        t_priority();
        t_mask_route();
        t_pulse();
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule